// File: doc/BRIEF.md
# Transmit Descriptor-Chain DMA Engine

This block feeds a MAC transmit FIFO from memory. Software prepares a linked run of 16-byte descriptors in memory, each pointing at a data buffer, and then requests a transmit pass. The engine walks the run one descriptor at a time, streams each buffer into the FIFO as 32-bit words, and stops at the first descriptor whose valid bit is clear.

Each descriptor holds a two-bit frame-position code, and that code decides how the descriptor is returned to software. A frame-start buffer is released as soon as its data has been moved. A frame-end buffer is released, with a sent flag, only after the MAC reports that frame as transmitted. A continuation buffer is never written back. The engine also paces itself. It fetches only while the FIFO has room and fewer than four complete frames are waiting in it, and it raises a maskable completion interrupt when the pass ends.

Top module: `txdesc_dma`

## Requirements
- R1: After reset, req_bits, done_stat and irq are 0, and neither mem_req nor fifo_wr is asserted.
- R2: A pass starts only while req_bits is 2'b11 (written through req_wr/req_wdata), tx_en is 1 and fifo_free is at least 8 words (32 bytes). No memory read is issued while any of these is missing.
- R3: The first descriptor fetched after reset is read at list_base. Every later fetch reads the address 16 above the previous descriptor. A new pass resumes at the descriptor that stopped the last one, regardless of list_base.
- R4: Descriptor layout: word 0 holds the valid bit at bit 31 and the frame-position code at bits 29:28. Word 1 bits 31:16 give the length in bytes. Word 2 gives the buffer byte address. For a valid descriptor, ceil(length/4) words are read from consecutive addresses and written to the FIFO in order. fifo_eof is set only on the last word of a buffer whose code is 01 or 11.
- R5: Code 10 (frame start): after its data has been moved, word 0 is written back with bit 31 cleared and every other bit unchanged.
- R6: Codes 01 and 11 (frame end): word 0 is written back with bit 31 cleared, bit 0 set and the other bits unchanged. The write happens only after a mac_frame_done pulse for that frame, and write-backs follow frame order.
- R7: Code 00 (continuation): the descriptor is never written, so bit 31 stays 1.
- R8: Reading a descriptor with bit 31 at 0 ends the pass. req_bits becomes 2'b00, done_stat becomes 2'b11, and nothing is moved for that descriptor.
- R9: Writing 1s through stat_clr_wr/stat_clr_data clears the matching done_stat bits. irq is 1 exactly when irq_en is 1 and done_stat is non-zero.
- R10: While four frames have been fully written to the FIFO without a matching mac_frame_done, no further descriptor is fetched.
- R11: A buffer word read is issued only while fifo_free is non-zero, so the FIFO is never written when full.
- R12: At most one memory read is outstanding. A read request is a single-cycle pulse, and the next request waits for mem_rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable |
| irq_en | input | 1 | Completion interrupt enable |
| list_base | input | AW | Address of the first descriptor after reset |
| req_wr | input | 1 | Write strobe for the request field |
| req_wdata | input | 2 | Value written to the request field |
| stat_clr_wr | input | 1 | Write strobe for clearing status |
| stat_clr_data | input | 2 | Status bits to clear (1 clears) |
| req_bits | output | 2 | Request field |
| done_stat | output | 2 | Transmit-complete status |
| irq | output | 1 | Completion interrupt |
| mem_req | output | 1 | Memory access request, one cycle |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | 32 | FIFO write data |
| fifo_eof | output | 1 | Marks the last word of a frame |
| fifo_free | input | FREE_W | Free FIFO space in words |
| mac_frame_done | input | 1 | One pulse per transmitted frame |

## Verification
A FIFO word appears on fifo_wr one cycle after the mem_rvalid that carried it. A frame-start write-back leaves on the cycle after the buffer's last word is stored. A frame-end write-back follows its mac_frame_done by at least two cycles. The stop status and irq change on the clock edge that takes in the invalid word 0. Memory latency is randomized, so the bench does not wait a fixed number of cycles for these results. Monitors compare every FIFO word and memory write on the edge where it occurs, and the end-of-pass checks are sampled on falling edges after a bounded poll has seen the stop status, all expected write-backs and an empty FIFO. The gating checks (R2, R10, R11) hold the blocking condition for far longer than one fetch takes, then sample the counters that a violation would have moved.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int VALID_BIT   = 31;
  localparam int CODE_HI     = 29;
  localparam int CODE_LO     = 28;
  localparam int LEN_HI      = 31;
  localparam int LEN_LO      = 16;
  localparam int LEN_W       = LEN_HI - LEN_LO + 1;
  localparam int SENT_BIT    = 0;
  localparam int DESC_STRIDE = 16;

  localparam logic [1:0] POS_START = 2'b10;

  typedef enum logic [2:0] {
    S_IDLE, S_GATE, S_RD, S_XFER, S_XSET, S_WBQ
  } tx_state_e;
endpackage

// File: rtl/txd_wbq.sv
module txd_wbq #(
  parameter int AW    = 32,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [31:0]   push_w0,
  input  logic          pop,
  output logic [AW-1:0] head_addr,
  output logic [31:0]   head_w0,
  output logic [CW-1:0] count
);
  logic [AW-1:0] addr_mem [DEPTH];
  logic [31:0]   w0_mem   [DEPTH];
  logic [PW-1:0] wp, rp;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) begin
      addr_mem[wp] <= push_addr;
      w0_mem[wp]   <= push_w0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      if (push && !pop)      count <= count + CW'(1);
      else if (pop && !push) count <= count - CW'(1);
    end
  end

  assign head_addr = addr_mem[rp];
  assign head_w0   = w0_mem[rp];

  AST_WBQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push |-> (count != CW'(DEPTH) || pop)); // R6
  AST_WBQ_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    pop |-> count != '0); // R6
endmodule

// File: rtl/txd_credit.sv
module txd_credit #(
  parameter int MAX_FRAMES = 4,
  parameter int QC_W       = 3,
  localparam int FC_W      = $clog2(MAX_FRAMES + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            frame_queued,
  input  logic            frame_done,
  input  logic            wb_issue,
  input  logic [QC_W-1:0] wbq_count,
  output logic            at_limit,
  output logic            has_pend
);
  logic [FC_W-1:0] held;
  logic [QC_W-1:0] pend;
  logic            dec, inc;

  assign dec = frame_done && (held != '0);
  assign inc = frame_done && (pend < wbq_count);

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= '0;
      pend <= '0;
    end else begin
      if (frame_queued && !dec)      held <= held + FC_W'(1);
      else if (dec && !frame_queued) held <= held - FC_W'(1);
      pend <= pend + QC_W'(inc) - QC_W'(wb_issue);
    end
  end

  assign at_limit = (held >= FC_W'(MAX_FRAMES));
  assign has_pend = (pend != '0);

  AST_FRAMES_BOUND: assert property (@(posedge clk) disable iff (rst)
    held <= FC_W'(MAX_FRAMES)); // R10
  AST_WB_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    wb_issue |-> pend != '0); // R6
endmodule

// File: rtl/txdesc_dma.sv
module txdesc_dma
  import txd_pkg::*;
#(
  parameter int AW          = 32,
  parameter int FREE_W      = 8,
  parameter int START_WORDS = 8,
  parameter int MAX_FRAMES  = 4,
  parameter int WBQ_DEPTH   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              irq_en,
  input  logic [AW-1:0]     list_base,
  input  logic              req_wr,
  input  logic [1:0]        req_wdata,
  input  logic              stat_clr_wr,
  input  logic [1:0]        stat_clr_data,
  output logic [1:0]        req_bits,
  output logic [1:0]        done_stat,
  output logic              irq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              fifo_wr,
  output logic [31:0]       fifo_wdata,
  output logic              fifo_eof,
  input  logic [FREE_W-1:0] fifo_free,
  input  logic              mac_frame_done
);
  localparam int QC_W = $clog2(WBQ_DEPTH + 1);

  tx_state_e        st;
  logic [AW-1:0]    ptr, baddr;
  logic             ptr_ok, run, waiting;
  logic [31:0]      w0;
  logic [LEN_W-1:0] words;
  logic [LEN_W:0]   lsum;
  logic [1:0]       widx;
  logic [1:0]       code;
  logic             is_end, xfer_end, stop;
  logic             start_ok, fetch_ok, room_ok;
  logic             q_push, q_pop, at_limit, has_pend;
  logic [AW-1:0]    q_addr;
  logic [31:0]      q_w0;
  logic [QC_W-1:0]  q_cnt;

  assign code     = w0[CODE_HI:CODE_LO];
  assign is_end   = code[0];
  assign room_ok  = fifo_free >= FREE_W'(START_WORDS);
  assign start_ok = (req_bits == 2'b11) && tx_en && room_ok;
  assign fetch_ok = !at_limit && (q_cnt != QC_W'(WBQ_DEPTH)) && room_ok;
  assign xfer_end = (st == S_XFER) && !waiting && (words == '0);
  assign stop     = (st == S_RD) && mem_rvalid && (widx == 2'd0) && !mem_rdata[VALID_BIT];
  assign q_push   = xfer_end && is_end;
  assign q_pop    = (st == S_WBQ);
  assign lsum     = {1'b0, mem_rdata[LEN_HI:LEN_LO]} + (LEN_W + 1)'(3);

  txd_wbq #(.AW(AW), .DEPTH(WBQ_DEPTH)) i_wbq (
    .clk(clk), .rst(rst), .push(q_push), .push_addr(ptr), .push_w0(w0),
    .pop(q_pop), .head_addr(q_addr), .head_w0(q_w0), .count(q_cnt)
  );

  txd_credit #(.MAX_FRAMES(MAX_FRAMES), .QC_W(QC_W)) i_credit (
    .clk(clk), .rst(rst), .frame_queued(q_push), .frame_done(mac_frame_done),
    .wb_issue(q_pop), .wbq_count(q_cnt), .at_limit(at_limit), .has_pend(has_pend)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_bits  <= 2'b00;
      done_stat <= 2'b00;
    end else begin
      if (stop)        req_bits <= 2'b00;
      else if (req_wr) req_bits <= req_wdata;
      done_stat <= (done_stat & ~(stat_clr_wr ? stat_clr_data : 2'b00))
                 | (stop ? 2'b11 : 2'b00);
    end
  end

  assign irq = irq_en && (done_stat != 2'b00);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      ptr        <= '0;
      baddr      <= '0;
      ptr_ok     <= 1'b0;
      run        <= 1'b0;
      waiting    <= 1'b0;
      w0         <= '0;
      words      <= '0;
      widx       <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      fifo_wr    <= 1'b0;
      fifo_wdata <= '0;
      fifo_eof   <= 1'b0;
    end else begin
      mem_req <= 1'b0;
      fifo_wr <= 1'b0;
      case (st)
        S_IDLE: begin
          if (has_pend) st <= S_WBQ;
          else if (start_ok) begin
            run <= 1'b1;
            if (!ptr_ok) begin
              ptr    <= list_base;
              ptr_ok <= 1'b1;
            end
            st <= S_GATE;
          end
        end
        S_GATE: begin
          if (has_pend) st <= S_WBQ;
          else if (fetch_ok) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= ptr;
            widx     <= 2'd0;
            st       <= S_RD;
          end
        end
        S_RD: begin
          if (mem_rvalid) begin
            case (widx)
              2'd0: begin
                w0 <= mem_rdata;
                if (!mem_rdata[VALID_BIT]) begin
                  run <= 1'b0;
                  st  <= S_IDLE;
                end else begin
                  mem_req  <= 1'b1;
                  mem_we   <= 1'b0;
                  mem_addr <= ptr + AW'(4);
                  widx     <= 2'd1;
                end
              end
              2'd1: begin
                words    <= {1'b0, lsum[LEN_W:2]};
                mem_req  <= 1'b1;
                mem_we   <= 1'b0;
                mem_addr <= ptr + AW'(8);
                widx     <= 2'd2;
              end
              default: begin
                baddr   <= mem_rdata[AW-1:0];
                waiting <= 1'b0;
                st      <= S_XFER;
              end
            endcase
          end
        end
        S_XFER: begin
          if (waiting) begin
            if (mem_rvalid) begin
              fifo_wr    <= 1'b1;
              fifo_wdata <= mem_rdata;
              fifo_eof   <= is_end && (words == LEN_W'(1));
              words      <= words - LEN_W'(1);
              baddr      <= baddr + AW'(4);
              waiting    <= 1'b0;
              st         <= S_XSET;
            end
          end else if (words == '0) begin
            if (code == POS_START) begin
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_addr  <= ptr;
              mem_wdata <= w0 & ~(32'd1 << VALID_BIT);
            end
            ptr <= ptr + AW'(DESC_STRIDE);
            st  <= S_GATE;
          end else if (fifo_free != '0) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= baddr;
            waiting  <= 1'b1;
          end
        end
        S_XSET: st <= S_XFER;
        S_WBQ: begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= q_addr;
          mem_wdata <= (q_w0 & ~(32'd1 << VALID_BIT)) | (32'd1 << SENT_BIT);
          st        <= run ? S_GATE : S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_STOP_STATUS: assert property (@(posedge clk) disable iff (rst)
    $fell(run) |-> (req_bits == 2'b00 && done_stat == 2'b11)); // R8
  AST_RD_ONE_OUT: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |=> !mem_req); // R12
  AST_RD_SPACE: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we && st == S_XFER) |-> $past(fifo_free) != '0); // R11
  AST_EOF_WORD_IN_PASS: assert property (@(posedge clk) disable iff (rst)
    fifo_wr |-> run); // R4
endmodule

// File: tb/test_txdesc_dma.sv
module test_txdesc_dma;
  localparam int FDEPTH = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tx_en = 1'b0, irq_en = 1'b1;
  logic [31:0] list_base = 32'h40;
  logic        req_wr = 1'b0, stat_clr_wr = 1'b0;
  logic [1:0]  req_wdata = 2'b00, stat_clr_data = 2'b00;
  logic [1:0]  req_bits, done_stat;
  logic        irq, mem_req, mem_we, fifo_wr, fifo_eof;
  logic [31:0] mem_addr, mem_wdata, fifo_wdata;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic [7:0]  fifo_free;
  logic        mac_frame_done;

  always #5 clk = ~clk;

  txdesc_dma i_txdesc_dma (
    .clk(clk), .rst(rst), .tx_en(tx_en), .irq_en(irq_en), .list_base(list_base),
    .req_wr(req_wr), .req_wdata(req_wdata), .stat_clr_wr(stat_clr_wr),
    .stat_clr_data(stat_clr_data), .req_bits(req_bits), .done_stat(done_stat), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .fifo_wr(fifo_wr),
    .fifo_wdata(fifo_wdata), .fifo_eof(fifo_eof), .fifo_free(fifo_free),
    .mac_frame_done(mac_frame_done)
  );

  int ntests = 0, nfail = 0;

  // memory model and write-back monitor
  logic [31:0] mem [0:4095];
  logic [31:0] rd_log [0:4095];
  logic        tb_we = 1'b0;
  logic [31:0] tb_a = '0, tb_d = '0;
  logic        rd_pend;
  logic [31:0] rd_a;
  int lat, rd_cnt = 0, done_cnt = 0, eofwb_cnt = 0, order_bad = 0;

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (tb_we) mem[tb_a[13:2]] <= tb_d;
    if (rst) begin
      rd_pend <= 1'b0;
    end else begin
      if (rd_pend) begin
        if (lat == 0) begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= mem[rd_a[13:2]];
          rd_pend    <= 1'b0;
        end else lat <= lat - 1;
      end
      if (mem_req && !mem_we) begin
        rd_pend <= 1'b1;
        rd_a    <= mem_addr;
        lat     <= int'($urandom % 3);
        rd_log[rd_cnt % 4096] <= mem_addr;
        rd_cnt  <= rd_cnt + 1;
      end
      if (mem_req && mem_we) begin
        mem[mem_addr[13:2]] <= mem_wdata;
        if (mem_wdata[0]) begin
          if (eofwb_cnt >= done_cnt) order_bad <= order_bad + 1;
          eofwb_cnt <= eofwb_cnt + 1;
        end
      end
      if (mac_frame_done) done_cnt <= done_cnt + 1;
    end
  end

  // FIFO, MAC and data monitor
  logic [32:0] fq [0:255];
  logic [32:0] expq [0:4095];
  int wp = 0, rp = 0, exp_wp = 0, exp_rp = 0, bad_data = 0, ovf = 0, eofw_cnt = 0;
  int mac_pend = 0, cap = FDEPTH;
  logic drain_en = 1'b1, mac_en = 1'b1;

  always_comb begin
    int room;
    room = FDEPTH - (wp - rp);
    fifo_free = 8'((room < cap) ? room : cap);
  end

  always @(posedge clk) begin
    int inc, dec;
    inc = 0; dec = 0;
    mac_frame_done <= 1'b0;
    if (rst) begin
      wp <= 0; rp <= 0; mac_pend <= 0;
    end else begin
      if (fifo_wr) begin
        if (wp - rp >= FDEPTH) ovf <= ovf + 1;
        fq[wp % 256] <= {fifo_eof, fifo_wdata};
        wp <= wp + 1;
        if (exp_rp >= exp_wp || {fifo_eof, fifo_wdata} != expq[exp_rp % 4096])
          bad_data <= bad_data + 1;
        exp_rp <= exp_rp + 1;
        if (fifo_eof) eofw_cnt <= eofw_cnt + 1;
      end
      if (drain_en && wp != rp && ($urandom % 4) != 0) begin
        rp <= rp + 1;
        if (fq[rp % 256][32]) inc = 1;
      end
      if (mac_en && mac_pend > 0) begin
        mac_frame_done <= 1'b1;
        dec = 1;
      end
      mac_pend <= mac_pend + inc - dec;
    end
  end

  task automatic chk(input string rq, input bit ok, input longint act, input longint expv);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, expv);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    tb_we = 1'b1; tb_a = a; tb_d = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  logic [31:0] dA [0:63];
  logic [31:0] dW [0:63];
  logic [1:0]  dC [0:63];
  int dn = 0, exp_eofwb = 0;
  logic [31:0] dptr = 32'h40;

  task automatic build(input int nfr, input int maxb, input int fixlen);
    logic [31:0] balloc = 32'h1000;
    dn = 0;
    for (int f = 0; f < nfr; f++) begin
      int nb = 1 + int'($urandom % maxb);
      for (int b = 0; b < nb; b++) begin
        logic [1:0] code;
        logic [31:0] w0;
        int len, nw;
        if (b == nb - 1)  code = ($urandom % 2) ? 2'b11 : 2'b01;
        else if (b == 0)  code = 2'b10;
        else              code = 2'b00;
        len = (fixlen > 0) ? fixlen : 1 + int'($urandom % 40);
        nw  = (len + 3) / 4;
        w0  = {1'b1, 1'b0, code, 28'($urandom) & 28'hFFFFFFE};
        poke(dptr, w0);
        poke(dptr + 4, {16'(len), 16'($urandom)});
        poke(dptr + 8, balloc);
        poke(dptr + 12, 32'h0);
        dA[dn] = dptr; dW[dn] = w0; dC[dn] = code; dn++;
        if (code[0]) exp_eofwb++;
        for (int w = 0; w < nw; w++) begin
          logic [31:0] d = $urandom;
          poke(balloc, d);
          expq[exp_wp % 4096] = {code[0] && (w == nw - 1), d};
          exp_wp++;
          balloc += 4;
        end
        dptr += 16;
      end
    end
    poke(dptr, 32'h0);
  endtask

  task automatic write_req(input logic [1:0] v);
    req_wr = 1'b1; req_wdata = v;
    @(negedge clk);
    req_wr = 1'b0;
  endtask

  task automatic clear_stat(input logic [1:0] v);
    stat_clr_wr = 1'b1; stat_clr_data = v;
    @(negedge clk);
    stat_clr_wr = 1'b0;
  endtask

  task automatic finish_pass(input logic [31:0] start, input int rd_snap);
    int t = 0, b5 = 0, b6 = 0, b7 = 0;
    while (!(done_stat == 2'b11 && eofwb_cnt == exp_eofwb && wp == rp && mac_pend == 0)
           && t < 20000) begin
      @(negedge clk); t++;
    end
    repeat (6) @(negedge clk);
    chk("R8 pass ends", t < 20000, t, 20000);
    chk("R8 req cleared", req_bits == 2'b00, req_bits, 0);
    chk("R8 status set", done_stat == 2'b11, done_stat, 3);
    chk("R3 first fetch address", rd_log[rd_snap % 4096] == start, rd_log[rd_snap % 4096], start);
    chk("R4 data stream", bad_data == 0 && exp_rp == exp_wp, bad_data, 0);
    chk("R6 order", order_bad == 0, order_bad, 0);
    chk("R11 no overrun", ovf == 0, ovf, 0);
    for (int i = 0; i < dn; i++) begin
      logic [31:0] m = mem[dA[i][13:2]];
      if (dC[i] == 2'b10 && m != (dW[i] & 32'h7FFFFFFF)) b5++;
      if (dC[i][0] && m != ((dW[i] & 32'h7FFFFFFF) | 32'h1)) b6++;
      if (dC[i] == 2'b00 && m != dW[i]) b7++;
    end
    chk("R5 start write-back", b5 == 0, b5, 0);
    chk("R6 end write-back", b6 == 0, b6, 0);
    chk("R7 continuation untouched", b7 == 0, b7, 0);
  endtask

  initial begin
    int snap, e0;
    logic [31:0] st;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 req", req_bits == 2'b00, req_bits, 0);
    chk("R1 stat", done_stat == 2'b00, done_stat, 0);
    chk("R1 irq", irq == 1'b0, irq, 0);
    chk("R1 mem_req", mem_req == 1'b0, mem_req, 0);
    chk("R1 fifo_wr", fifo_wr == 1'b0, fifo_wr, 0);

    // first pass with start gating (R2) and list base (R3)
    build(3, 3, 0);
    write_req(2'b11);
    repeat (20) @(negedge clk);
    chk("R2 no start without tx_en", rd_cnt == 0, rd_cnt, 0);
    cap = 7; tx_en = 1'b1;
    repeat (20) @(negedge clk);
    chk("R2 no start below 32 bytes", rd_cnt == 0, rd_cnt, 0);
    cap = FDEPTH;
    finish_pass(32'h40, 0);
    chk("R9 irq with enable", irq == 1'b1, irq, 1);
    clear_stat(2'b01);
    chk("R9 partial clear", done_stat == 2'b10 && irq == 1'b1, done_stat, 2);
    clear_stat(2'b10);
    chk("R9 full clear", done_stat == 2'b00 && irq == 1'b0, done_stat, 0);

    // resume at stopping descriptor regardless of base (R3), irq masked (R9)
    list_base = 32'h800;
    irq_en = 1'b0;
    st = dptr; snap = rd_cnt;
    build(2, 2, 5);
    write_req(2'b11);
    finish_pass(st, snap);
    chk("R9 irq masked", irq == 1'b0, irq, 0);
    irq_en = 1'b1;
    clear_stat(2'b11);

    // random passes
    for (int r = 0; r < 6; r++) begin
      st = dptr; snap = rd_cnt;
      build(1 + int'($urandom % 5), 3, 0);
      write_req(2'b11);
      finish_pass(st, snap);
      clear_stat(2'b11);
    end

    // four-frame limit (R10)
    mac_en = 1'b0;
    st = dptr; snap = rd_cnt; e0 = eofw_cnt;
    build(6, 1, 8);
    write_req(2'b11);
    repeat (300) @(negedge clk);
    chk("R10 four frames held", eofw_cnt - e0 == 4, eofw_cnt - e0, 4);
    chk("R10 pass still open", done_stat == 2'b00, done_stat, 0);
    mac_en = 1'b1;
    finish_pass(st, snap);
    chk("R10 all frames after release", eofw_cnt - e0 == 6, eofw_cnt - e0, 6);
    clear_stat(2'b11);

    // full FIFO pause (R11)
    drain_en = 1'b0;
    st = dptr; snap = rd_cnt;
    build(1, 1, 400);
    write_req(2'b11);
    repeat (600) @(negedge clk);
    chk("R11 fills to depth", wp - rp == FDEPTH, wp - rp, FDEPTH);
    chk("R11 no write when full", ovf == 0, ovf, 0);
    drain_en = 1'b1;
    finish_pass(st, snap);

    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", ntests + 1, nfail + 1);
    $finish;
  end
endmodule